// File: doc/BRIEF.md
# Multiplexed Processor Bus System Agent

This block is the system-side agent on a single-master processor bus. Address and data share one 64-bit path, with eight even parity bits (one per byte) and a 9-bit command word. Every signal is sampled on the rising edge of the bus clock. The processor issues reads and writes by driving its active-low output-valid strobe. The agent stores write data in a small word-addressed memory model and returns read data under its own active-low input-valid strobe. It paces the processor with active-low read-ready and write-ready lines.

Writes follow the reissue convention. A write whose command cycle arrives while write-ready is deasserted is thrown away in full, because the processor will send it again. A local request input makes the agent raise its active-low external-request line. It then waits for the processor's one-cycle release pulse and holds the bus quietly until told to return it. To return the bus it drives a release-null command with input-valid asserted for one cycle.

The command word is laid out as follows. Bit 8 is 1 for a command cycle and 0 for a data cycle. In a command cycle, bits 7:5 give the operation: 000 read, 100 write, 011 release-null. Bit 3 is 1 for a four-beat line transfer and 0 for a single word. In a data cycle, bit 7 marks the last beat and bit 4 asks the processor to generate parity itself. The word index is taken from address bits 3 and up.

Top module: `mpa_agent`

## Requirements
- R1: Out of reset agent_valid_n and ext_req_n are 1, bus_owned and perr are 0, and with both hold inputs low rd_rdy_n and wr_rdy_n are 0.
- R2: A read command cycle (bit 8 = 1, bits 7:5 = 000) accepted with rd_rdy_n low is answered on the following cycles. The answer is one beat, or four beats when bit 3 is 1, each with agent_valid_n low and command bit 8 at 0. Bit 7 is set on the last beat only. The first reply beat appears in the cycle right after the command cycle.
- R3: Line transfers visit the four words of the aligned line in order, starting at the addressed word and wrapping within the line. For example, start word 5 gives words 5, 6, 7, 4.
- R4: A write command cycle (bits 7:5 = 100) accepted with wr_rdy_n low stores each following data beat (cpu_valid_n low, bit 8 = 0) in turn. The beat flagged by bit 7 ends the write.
- R5: A write whose command cycle arrives while wr_rdy_n is 1 is ignored, including all of its data beats. Memory is unchanged, and a later read shows this.
- R6: A read command cycle that arrives while rd_rdy_n is 1 produces no reply; agent_valid_n stays 1.
- R7: With par_gen_mode low, every reply beat has command bit 4 clear. Each bit of bus_par_out then makes its byte plus that bit even (bit i covers bits 8i+7:8i).
- R8: With par_gen_mode high, every reply beat has command bit 4 set and all eight parity bits at 1.
- R9: An accepted write data beat whose parity does not match sets perr. perr stays set until perr_clr is pulsed, and clean beats leave it clear.
- R10: Raising own_req while idle drives ext_req_n low in the next cycle. From then until the bus is returned, rd_rdy_n and wr_rdy_n are held at 1.
- R11: A cycle with cpu_release_n low while the request is pending makes bus_owned 1 in the next cycle. While the bus is owned, agent_valid_n stays 1.
- R12: own_done while the bus is owned yields exactly one cycle of agent_valid_n low with command 1_011_0_0000 (release-null). In the cycle after that, ext_req_n is 1, bus_owned is 0 and the ready lines follow the hold inputs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid_n | input | 1 | Processor output-valid strobe, active low |
| cpu_release_n | input | 1 | Processor release pulse, active low |
| bus_ad_in | input | 64 | Address/data driven by the processor |
| bus_par_in | input | 8 | Byte parity driven by the processor |
| bus_cmd_in | input | 9 | Command word driven by the processor |
| bus_ad_out | output | 64 | Read data driven by the agent |
| bus_par_out | output | 8 | Byte parity driven by the agent |
| bus_cmd_out | output | 9 | Command word driven by the agent |
| agent_valid_n | output | 1 | Agent input-valid strobe, active low |
| rd_rdy_n | output | 1 | Read-ready, active low |
| wr_rdy_n | output | 1 | Write-ready, active low |
| ext_req_n | output | 1 | External bus request, active low |
| hold_rd | input | 1 | Local throttle: deassert read-ready |
| hold_wr | input | 1 | Local throttle: deassert write-ready |
| par_gen_mode | input | 1 | Ask the processor to generate parity on reply data |
| own_req | input | 1 | Local demand to take the bus |
| own_done | input | 1 | Local demand to return the bus |
| bus_owned | output | 1 | Agent currently holds the bus |
| perr | output | 1 | Sticky write-data parity error |
| perr_clr | input | 1 | Clears perr |

## Verification
Each fault in the state machine shows at the ports within a cycle or two. A wrong beat counter or line base shows up in the next reply as the wrong word, or as a last-beat flag in the wrong place. A dropped write that is stored anyway is caught only by a later read of the same word, so every reissue case is followed by a read-back. A mastership state that is stuck or skipped shows in the very next cycle on ext_req_n, bus_owned or the ready lines, and a missing release-null shows in the single cycle meant to carry it.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    localparam int DATA_W   = 64;
    localparam int NBYTES   = DATA_W / 8;
    localparam int CMD_W    = 9;
    localparam int LINE_BEATS = 4;
    localparam int BEAT_W   = $clog2(LINE_BEATS);
    localparam int WORD_LSB = $clog2(NBYTES);

    // command word bit positions
    localparam int CB_CYC   = 8;
    localparam int CB_LAST  = 7;
    localparam int CB_OP_HI = 7;
    localparam int CB_OP_LO = 5;
    localparam int CB_PGEN  = 4;
    localparam int CB_BLOCK = 3;

    typedef enum logic [2:0] {
        OP_READ    = 3'b000,
        OP_WRITE   = 3'b100,
        OP_RELNULL = 3'b011
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_WDROP,
        ST_REQ,
        ST_OWN,
        ST_REL
    } state_e;

    typedef struct packed {
        logic [DATA_W-1:0] ad;
        logic [NBYTES-1:0] par;
        logic [CMD_W-1:0]  cmd;
    } bus_word_t;

    function automatic logic [CMD_W-1:0] cmd_cycle(input op_e op, input logic blk);
        logic [CMD_W-1:0] c;
        c = '0;
        c[CB_CYC] = 1'b1;
        c[CB_OP_HI:CB_OP_LO] = op;
        c[CB_BLOCK] = blk;
        return c;
    endfunction

    function automatic logic [CMD_W-1:0] data_cycle(input logic last, input logic pgen);
        logic [CMD_W-1:0] c;
        c = '0;
        c[CB_LAST] = last;
        c[CB_PGEN] = pgen;
        return c;
    endfunction

endpackage

// File: rtl/mpa_parity.sv
module mpa_parity #(
    parameter int NB = 8
) (
    input  logic [NB*8-1:0] data,
    input  logic [NB-1:0]   par_ref,
    output logic [NB-1:0]   par_calc,
    output logic            mismatch
);
    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_byte
            assign par_calc[g] = ^data[g*8 +: 8];
        end
    endgenerate

    assign mismatch = |(par_calc ^ par_ref);
endmodule

// File: rtl/mpa_mem.sv
module mpa_mem #(
    parameter int AW = 6,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = store[addr];
endmodule

// File: rtl/mpa_ctrl.sv
module mpa_ctrl
    import mpa_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid_n,
    input  logic              cpu_release_n,
    input  logic [CMD_W-1:0]  cmd_in,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              hold_rd,
    input  logic              hold_wr,
    input  logic              own_req,
    input  logic              own_done,
    input  logic              par_bad,
    input  logic              perr_clr,
    output state_e            state,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic              last_beat,
    output logic              rd_rdy_n,
    output logic              wr_rdy_n,
    output logic              ext_req_n,
    output logic              bus_owned,
    output logic              perr
);
    state_e            st_q, st_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [AW-1:0]     base_q, base_d;
    logic              blk_q, blk_d;
    logic              perr_q;

    logic cmd_seen, data_seen, rdy_block;
    logic [2:0] op_bits;

    always_comb begin
        cmd_seen  = !cpu_valid_n && cmd_in[CB_CYC];
        data_seen = !cpu_valid_n && !cmd_in[CB_CYC];
        op_bits   = cmd_in[CB_OP_HI:CB_OP_LO];
        rdy_block = (st_q == ST_REQ) || (st_q == ST_OWN) || (st_q == ST_REL);
        rd_rdy_n  = hold_rd || rdy_block;
        wr_rdy_n  = hold_wr || rdy_block;
        ext_req_n = !((st_q == ST_REQ) || (st_q == ST_OWN));
        bus_owned = (st_q == ST_OWN);
        mem_addr  = {base_q[AW-1:BEAT_W], base_q[BEAT_W-1:0] + beat_q};
        last_beat = blk_q ? (beat_q == BEAT_W'(LINE_BEATS-1)) : 1'b1;
        mem_we    = (st_q == ST_WR) && data_seen;
    end

    always_comb begin
        st_d   = st_q;
        beat_d = beat_q;
        base_d = base_q;
        blk_d  = blk_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_seen && op_bits == OP_READ && !rd_rdy_n) begin
                    st_d   = ST_RD;
                    beat_d = '0;
                    base_d = ad_in[WORD_LSB +: AW];
                    blk_d  = cmd_in[CB_BLOCK];
                end else if (cmd_seen && op_bits == OP_WRITE) begin
                    st_d   = wr_rdy_n ? ST_WDROP : ST_WR;
                    beat_d = '0;
                    base_d = ad_in[WORD_LSB +: AW];
                    blk_d  = cmd_in[CB_BLOCK];
                end else if (own_req) begin
                    st_d = ST_REQ;
                end
            end
            ST_RD: begin
                beat_d = beat_q + 1'b1;
                if (last_beat) st_d = ST_IDLE;
            end
            ST_WR: begin
                if (data_seen) begin
                    beat_d = beat_q + 1'b1;
                    if (cmd_in[CB_LAST]) st_d = ST_IDLE;
                end
            end
            ST_WDROP: begin
                if (data_seen && cmd_in[CB_LAST]) st_d = ST_IDLE;
            end
            ST_REQ: begin
                if (!cpu_release_n) st_d = ST_OWN;
            end
            ST_OWN: begin
                if (own_done) st_d = ST_REL;
            end
            ST_REL: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
            base_q <= '0;
            blk_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            beat_q <= beat_d;
            base_q <= base_d;
            blk_q  <= blk_d;
            if (mem_we && par_bad) perr_q <= 1'b1;
            else if (perr_clr)     perr_q <= 1'b0;
        end
    end

    assign state = st_q;
    assign perr  = perr_q;
endmodule

// File: rtl/mpa_agent.sv
module mpa_agent
    import mpa_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_valid_n,
    input  logic        cpu_release_n,
    input  logic [63:0] bus_ad_in,
    input  logic [7:0]  bus_par_in,
    input  logic [8:0]  bus_cmd_in,
    output logic [63:0] bus_ad_out,
    output logic [7:0]  bus_par_out,
    output logic [8:0]  bus_cmd_out,
    output logic        agent_valid_n,
    output logic        rd_rdy_n,
    output logic        wr_rdy_n,
    output logic        ext_req_n,
    input  logic        hold_rd,
    input  logic        hold_wr,
    input  logic        par_gen_mode,
    input  logic        own_req,
    input  logic        own_done,
    output logic        bus_owned,
    output logic        perr,
    input  logic        perr_clr
);
    state_e            state;
    logic              mem_we, last_beat, par_bad, unused_mm;
    logic [AW-1:0]     mem_addr;
    logic [DATA_W-1:0] rdata;
    logic [NBYTES-1:0] par_rd, par_wr_calc;
    bus_word_t         drv;

    mpa_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_valid_n(cpu_valid_n), .cpu_release_n(cpu_release_n),
        .cmd_in(bus_cmd_in), .ad_in(bus_ad_in),
        .hold_rd(hold_rd), .hold_wr(hold_wr),
        .own_req(own_req), .own_done(own_done),
        .par_bad(par_bad), .perr_clr(perr_clr),
        .state(state), .mem_we(mem_we), .mem_addr(mem_addr),
        .last_beat(last_beat), .rd_rdy_n(rd_rdy_n), .wr_rdy_n(wr_rdy_n),
        .ext_req_n(ext_req_n), .bus_owned(bus_owned), .perr(perr)
    );

    mpa_mem #(.AW(AW), .DW(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .addr(mem_addr),
        .wdata(bus_ad_in), .rdata(rdata)
    );

    mpa_parity #(.NB(NBYTES)) u_chk_par (
        .data(bus_ad_in), .par_ref(bus_par_in),
        .par_calc(par_wr_calc), .mismatch(par_bad)
    );

    mpa_parity #(.NB(NBYTES)) u_gen_par (
        .data(rdata), .par_ref('0),
        .par_calc(par_rd), .mismatch(unused_mm)
    );

    always_comb begin
        drv = '0;
        if (state == ST_RD) begin
            drv.ad  = rdata;
            drv.par = par_gen_mode ? '1 : par_rd;
            drv.cmd = data_cycle(last_beat, par_gen_mode);
        end else if (state == ST_REL) begin
            drv.cmd = cmd_cycle(OP_RELNULL, 1'b0);
        end
    end

    assign bus_ad_out    = drv.ad;
    assign bus_par_out   = drv.par;
    assign bus_cmd_out   = drv.cmd;
    assign agent_valid_n = !((state == ST_RD) || (state == ST_REL));
endmodule

// File: rtl/mpa_agent_chk.sv
module mpa_agent_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_release_n,
    input logic [63:0] bus_ad_out,
    input logic [7:0] bus_par_out,
    input logic [8:0] bus_cmd_out,
    input logic       agent_valid_n,
    input logic       rd_rdy_n,
    input logic       wr_rdy_n,
    input logic       ext_req_n,
    input logic       par_gen_mode,
    input logic       bus_owned,
    input logic       perr,
    input logic       perr_clr
);
    logic par_even;
    always_comb begin
        par_even = 1'b1;
        for (int i = 0; i < 8; i++)
            if (^{bus_par_out[i], bus_ad_out[i*8 +: 8]}) par_even = 1'b0;
    end

    AST_REQ_HOLDS_RDY: assert property (@(posedge clk) disable iff (rst)
        !ext_req_n |-> (rd_rdy_n && wr_rdy_n)); // R10
    AST_OWNED_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_owned |-> agent_valid_n); // R11
    AST_GRANT_FROM_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_owned) |-> $past(!cpu_release_n)); // R11
    AST_RETURN_ENDS_OWN: assert property (@(posedge clk) disable iff (rst)
        (!agent_valid_n && bus_cmd_out[8]) |=> (!bus_owned && ext_req_n)); // R12
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (perr && !perr_clr) |=> perr); // R9
    AST_DATA_EVEN_PAR: assert property (@(posedge clk) disable iff (rst)
        (!agent_valid_n && !bus_cmd_out[8] && !par_gen_mode) |-> (par_even && !bus_cmd_out[4])); // R7
    AST_PGEN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!agent_valid_n && !bus_cmd_out[8] && par_gen_mode) |-> (bus_cmd_out[4] && (&bus_par_out))); // R8
endmodule

bind mpa_agent mpa_agent_chk u_agent_chk (
    .clk(clk), .rst(rst), .cpu_release_n(cpu_release_n),
    .bus_ad_out(bus_ad_out), .bus_par_out(bus_par_out), .bus_cmd_out(bus_cmd_out),
    .agent_valid_n(agent_valid_n), .rd_rdy_n(rd_rdy_n), .wr_rdy_n(wr_rdy_n),
    .ext_req_n(ext_req_n), .par_gen_mode(par_gen_mode), .bus_owned(bus_owned),
    .perr(perr), .perr_clr(perr_clr)
);

// File: tb/mpa_agent_bench.sv
module mpa_agent_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_valid_n, cpu_release_n;
    logic [63:0] bus_ad_in;
    logic [7:0]  bus_par_in;
    logic [8:0]  bus_cmd_in;
    logic [63:0] bus_ad_out;
    logic [7:0]  bus_par_out;
    logic [8:0]  bus_cmd_out;
    logic        agent_valid_n, rd_rdy_n, wr_rdy_n, ext_req_n;
    logic        hold_rd, hold_wr, par_gen_mode, own_req, own_done;
    logic        bus_owned, perr, perr_clr;

    int n_run = 0, n_fail = 0;
    logic [63:0] model [64];

    always #2 clk = ~clk;

    mpa_agent u_mpa_agent (.*);

    function automatic logic [7:0] epar(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        cpu_valid_n = 1'b1; cpu_release_n = 1'b1;
        bus_ad_in = '0; bus_par_in = '0; bus_cmd_in = '0;
    endtask

    task automatic cpu_write(input int idx, input bit blk, input logic [63:0] seed, input bit bad, input bit dropped);
        int n;
        n = blk ? 4 : 1;
        @(negedge clk);
        cpu_valid_n = 1'b0; bus_ad_in = 64'(idx) << 3;
        bus_cmd_in = {1'b1, 3'b100, 1'b0, blk, 3'b000};
        bus_par_in = epar(bus_ad_in);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            bus_ad_in  = seed + 64'(b) * 64'h0101_0101_0101_0101;
            bus_par_in = epar(bus_ad_in) ^ (bad ? 8'h01 : 8'h00);
            bus_cmd_in = {1'b0, b == n - 1, 7'b0};
            if (!dropped) model[(idx & ~3) | ((idx + b) & 3)] = bus_ad_in;
        end
        @(negedge clk);
        idle_bus();
    endtask

    task automatic cpu_read(input int idx, input bit blk, input string req);
        int n;
        int w;
        n = blk ? 4 : 1;
        @(negedge clk);
        cpu_valid_n = 1'b0; cpu_release_n = 1'b0; bus_ad_in = 64'(idx) << 3;
        bus_cmd_in = {1'b1, 3'b000, 1'b0, blk, 3'b000};
        bus_par_in = epar(bus_ad_in);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            idle_bus();
            w = (idx & ~3) | ((idx + b) & 3);
            chk(agent_valid_n == 1'b0, {req, " valid"}, 64'(agent_valid_n), 64'd0);
            chk(bus_ad_out == model[w], {req, " data"}, bus_ad_out, model[w]);
            chk(bus_cmd_out[8] == 1'b0 && bus_cmd_out[7] == (b == n - 1), {req, " R2 last flag"},
                64'(bus_cmd_out), 64'(b == n - 1) << 7);
            if (!par_gen_mode)
                chk(bus_par_out == epar(bus_ad_out) && !bus_cmd_out[4], "R7 parity",
                    64'(bus_par_out), 64'(epar(bus_ad_out)));
            else
                chk(bus_par_out == 8'hFF && bus_cmd_out[4], "R8 gen mode",
                    {55'd0, bus_cmd_out[4], bus_par_out}, 64'h1FF);
        end
        @(negedge clk);
        chk(agent_valid_n == 1'b1, {req, " end"}, 64'(agent_valid_n), 64'd1);
    endtask

    task automatic t_reset();
        chk(agent_valid_n && ext_req_n && !bus_owned && !perr && !rd_rdy_n && !wr_rdy_n, "R1 reset",
            {58'd0, agent_valid_n, ext_req_n, bus_owned, perr, rd_rdy_n, wr_rdy_n}, 64'h30);
    endtask

    task automatic t_single();
        cpu_write(9, 1'b0, 64'hDEAD_BEEF_0123_4567, 1'b0, 1'b0);
        cpu_read(9, 1'b0, "R2 R4 single");
        cpu_write(2, 1'b0, 64'hFFFF_0000_A5A5_0F0F, 1'b0, 1'b0);
        cpu_read(2, 1'b0, "R2 R4 single b");
    endtask

    task automatic t_block();
        cpu_write(5, 1'b1, 64'h1111_2222_3333_4444, 1'b0, 1'b0);
        cpu_read(5, 1'b1, "R3 block wrap");
        cpu_read(6, 1'b1, "R3 block wrap2");
        cpu_write(12, 1'b1, 64'h8080_7070_6060_5050, 1'b0, 1'b0);
        cpu_read(15, 1'b1, "R3 R4 line top");
    endtask

    task automatic t_reissue();
        @(negedge clk); hold_wr = 1'b1;
        @(negedge clk);
        chk(wr_rdy_n == 1'b1, "R5 wr_rdy", 64'(wr_rdy_n), 64'd1);
        cpu_write(9, 1'b0, 64'h0BAD_0BAD_0BAD_0BAD, 1'b0, 1'b1);
        cpu_write(4, 1'b1, 64'hCAFE_0000_0000_0000, 1'b0, 1'b1);
        hold_wr = 1'b0;
        cpu_read(9, 1'b0, "R5 dropped single");
        cpu_read(4, 1'b1, "R5 dropped block");
        cpu_write(9, 1'b0, 64'h0BAD_0BAD_0BAD_0BAD, 1'b0, 1'b0);
        cpu_read(9, 1'b0, "R5 reissued");
    endtask

    task automatic t_rd_blocked();
        @(negedge clk); hold_rd = 1'b1;
        @(negedge clk);
        chk(rd_rdy_n == 1'b1, "R6 rd_rdy", 64'(rd_rdy_n), 64'd1);
        cpu_valid_n = 1'b0; cpu_release_n = 1'b0; bus_ad_in = 64'd9 << 3;
        bus_cmd_in = {1'b1, 3'b000, 5'b0};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            idle_bus();
            chk(agent_valid_n == 1'b1, "R6 no reply", 64'(agent_valid_n), 64'd1);
        end
        hold_rd = 1'b0;
    endtask

    task automatic t_pgen();
        par_gen_mode = 1'b1;
        cpu_read(5, 1'b1, "R8 block");
        par_gen_mode = 1'b0;
    endtask

    task automatic t_perr();
        chk(perr == 1'b0, "R9 clean", 64'(perr), 64'd0);
        cpu_write(20, 1'b0, 64'h0000_0000_0000_00FF, 1'b1, 1'b0);
        chk(perr == 1'b1, "R9 set", 64'(perr), 64'd1);
        cpu_write(21, 1'b0, 64'h1234, 1'b0, 1'b0);
        chk(perr == 1'b1, "R9 sticky", 64'(perr), 64'd1);
        @(negedge clk); perr_clr = 1'b1;
        @(negedge clk); perr_clr = 1'b0;
        chk(perr == 1'b0, "R9 cleared", 64'(perr), 64'd0);
    endtask

    task automatic t_master();
        @(negedge clk); own_req = 1'b1;
        @(negedge clk); own_req = 1'b0;
        chk(ext_req_n == 1'b0, "R10 req", 64'(ext_req_n), 64'd0);
        chk(rd_rdy_n && wr_rdy_n, "R10 rdy held", {62'd0, rd_rdy_n, wr_rdy_n}, 64'd3);
        @(negedge clk);
        chk(bus_owned == 1'b0 && ext_req_n == 1'b0, "R11 wait grant", 64'(bus_owned), 64'd0);
        cpu_release_n = 1'b0;
        @(negedge clk); cpu_release_n = 1'b1;
        chk(bus_owned == 1'b1, "R11 granted", 64'(bus_owned), 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(agent_valid_n && bus_owned && rd_rdy_n && wr_rdy_n, "R11 quiet",
                {61'd0, agent_valid_n, bus_owned, rd_rdy_n}, 64'd7);
        end
        own_done = 1'b1;
        @(negedge clk); own_done = 1'b0;
        chk(agent_valid_n == 1'b0 && bus_cmd_out == 9'b1_011_0_0000, "R12 release-null",
            {54'd0, agent_valid_n, bus_cmd_out}, 64'h160);
        @(negedge clk);
        chk(agent_valid_n && ext_req_n && !bus_owned && !rd_rdy_n && !wr_rdy_n, "R12 returned",
            {59'd0, agent_valid_n, ext_req_n, bus_owned, rd_rdy_n, wr_rdy_n}, 64'h18);
        cpu_read(9, 1'b0, "R12 after return");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_bus();
        hold_rd = 0; hold_wr = 0; par_gen_mode = 0; own_req = 0; own_done = 0; perr_clr = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_block();
        t_reissue();
        t_rd_blocked();
        t_pgen();
        t_perr();
        t_master();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule